// File: doc/BRIEF.md
# SECDED Read-Path Syndrome Decoder

This block protects a memory word of 32 data bits with 7 check bits. On the write side it computes the check bits for a data word, so the memory stores a 39-bit code word. On the read side it recomputes the check bits from the returned word and forms an 8-bit syndrome. From that syndrome it classifies the read as clean, single-bit correctable or uncorrectable. For a correctable read it inverts the failing bit.

Every column of the parity matrix has odd weight. Because of this, the parity of the 7-bit syndrome equals the overall parity of the code word, and no separate parity store is needed. Several syndrome-to-bit assignments are fixed and are not positional. The remaining data bits are assigned by a rule, so the matrix is computed rather than tabulated.

Read results come out one clock after the read strobe. When an error is detected, a status register takes the syndrome on that same edge. It keeps that value until the next error.

Top module: `secded_rd_chk`

## Requirements
- R1: `wr_ecc_o[j]` is the XOR of every `wr_data_i[i]` whose matrix column has bit j set. This is combinational and uses the same matrix as the read path.
- R2: These fixed columns apply to data bits: 0→0x43, 1→0x45, 2→0x46, 3→0x49, 4→0x4a, 5→0x4c, 6→0x51, 7→0x52, 8→0x54, 21→0x4f, 31→0x07. Check bit j has column `1<<j`.
- R3: The other 21 data bits take the weight-3 7-bit values that no fixed column uses. Both are taken in increasing order: the lowest free value goes to the lowest unassigned data bit.
- R4: A read word with a zero syndrome is clean. One cycle after `rd_valid_i`, `rd_valid_o` is high and `rd_data_o` equals the stored data (word bits [31:0]). `sbe_o` and `mbe_o` are low.
- R5: A single flipped data bit gives `sbe_o`=1 and `rd_data_o` equal to the original data. The syndrome is {1'b0, column of that bit}.
- R6: A single flipped check bit (word bits [38:32] = check bits 6..0) gives `sbe_o`=1 and the data unchanged. The syndrome is one-hot, `1<<j`.
- R7: Two flipped bits give `mbe_o`=1 and `sbe_o`=0. The syndrome is {1'b1, XOR of the two columns}. Syndrome bit 7 is set when the 7-bit part is non-zero with even weight.
- R8: `sbe_o` and `mbe_o` are never high together. They are only high in a cycle where `rd_valid_o` is high.
- R9: `syn_o` resets to 0. It loads the syndrome on the edge that registers an erroneous read, and otherwise holds its value.
- R10: With `rd_valid_i` low, the word is ignored. `rd_valid_o`, `sbe_o` and `mbe_o` stay low next cycle, and `syn_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 32 | Data to encode |
| wr_ecc_o | output | 7 | Check bits for `wr_data_i` |
| rd_valid_i | input | 1 | Read word strobe |
| rd_word_i | input | 39 | Read code word: [31:0] data, [38:32] check bits |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 32 | Corrected read data |
| sbe_o | output | 1 | Correctable single-bit error |
| mbe_o | output | 1 | Uncorrectable error |
| syn_o | output | 8 | Syndrome of most recent error |

## Verification
The assertions check four properties on every cycle:
- the flags are exclusive and appear only with valid;
- valid follows the strobe by one cycle;
- a single-bit flag always carries an odd-weight syndrome with bit 7 clear;
- the status register holds whenever no flag is raised, and a clean read passes its data through unchanged.

Only the bench's sweeps can show the rest:
- that the matrix matches the fixed and derived assignments;
- that each of the 39 single flips is corrected to the original word;
- that every one of the 741 bit pairs is reported uncorrectable with the expected syndrome.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int ECC_W  = 7;
  localparam int WORD_W = DATA_W + ECC_W;
  localparam int SYN_W  = ECC_W + 1;

  typedef logic [DATA_W-1:0][ECC_W-1:0] col_arr_t;

  // fixed columns first, then free weight-3 codes in ascending order
  function automatic col_arr_t build_cols();
    col_arr_t c;
    logic [DATA_W-1:0] taken;
    c = '0;
    taken = '0;
    c[0]  = 7'h43; c[1] = 7'h45; c[2] = 7'h46; c[3] = 7'h49;
    c[4]  = 7'h4a; c[5] = 7'h4c; c[6] = 7'h51; c[7] = 7'h52;
    c[8]  = 7'h54; c[21] = 7'h4f; c[31] = 7'h07;
    taken[8:0] = '1;
    taken[21]  = 1'b1;
    taken[31]  = 1'b1;
    for (int v = 1; v < (1 << ECC_W); v++) begin
      logic [ECC_W-1:0] code;
      logic used;
      logic placed;
      code = ECC_W'(v);
      used = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (taken[i] && c[i] == code) used = 1'b1;
      if ($countones(code) == 3 && !used) begin
        placed = 1'b0;
        for (int i = 0; i < DATA_W; i++)
          if (!placed && !taken[i]) begin
            c[i] = code;
            taken[i] = 1'b1;
            placed = 1'b1;
          end
      end
    end
    return c;
  endfunction

  localparam col_arr_t DCOL = build_cols();
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o
);
  for (genvar j = 0; j < ECC_W; j++) begin : g_row
    logic [DATA_W-1:0] mask;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign mask[i] = DCOL[i][j];
    end
    assign ecc_o[j] = ^(data_i & mask);
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [ECC_W-1:0]  ecc_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              mbe_o,
  output logic [SYN_W-1:0]  syn_o
);
  logic [ECC_W-1:0]  ecc_calc;
  logic [ECC_W-1:0]  h;
  logic [DATA_W-1:0] hit_d;
  logic              nz, odd, hit_c, fixable;

  secded_enc u_enc (.data_i(data_i), .ecc_o(ecc_calc));

  assign h   = ecc_calc ^ ecc_i;
  assign nz  = |h;
  assign odd = ^h;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    assign hit_d[i] = (h == DCOL[i]);
  end

  assign hit_c   = nz && ((h & (h - ECC_W'(1))) == '0);
  assign fixable = odd && (hit_c || (|hit_d));

  assign data_o = data_i ^ hit_d;
  assign sbe_o  = fixable;
  assign mbe_o  = nz && !fixable;
  assign syn_o  = {nz && !odd, h};  // bit 7: even-weight non-zero syndrome
endmodule

// File: rtl/secded_syn_hold.sv
module secded_syn_hold
  import secded_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [SYN_W-1:0] syn_i,
  output logic [SYN_W-1:0] syn_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    syn_o <= '0;
    else if (cap_i) syn_o <= syn_i;
endmodule

// File: rtl/secded_rd_chk.sv
module secded_rd_chk
  import secded_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       wr_data_i,
  output logic [6:0]        wr_ecc_o,
  input  logic              rd_valid_i,
  input  logic [38:0]       rd_word_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              sbe_o,
  output logic              mbe_o,
  output logic [7:0]        syn_o
);
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbe, dec_mbe;
  logic [SYN_W-1:0]  dec_syn;
  logic              cap;

  secded_enc u_wr_enc (.data_i(wr_data_i), .ecc_o(wr_ecc_o));

  secded_dec u_dec (
    .data_i (rd_word_i[DATA_W-1:0]),
    .ecc_i  (rd_word_i[WORD_W-1:DATA_W]),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .mbe_o  (dec_mbe),
    .syn_o  (dec_syn)
  );

  assign cap = rd_valid_i && (dec_sbe || dec_mbe);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      sbe_o      <= 1'b0;
      mbe_o      <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_valid_i;
      sbe_o      <= rd_valid_i && dec_sbe;
      mbe_o      <= rd_valid_i && dec_mbe;
      if (rd_valid_i) rd_data_o <= dec_data;
    end

  secded_syn_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .syn_i  (dec_syn),
    .syn_o  (syn_o)
  );
endmodule

// File: rtl/secded_rd_chk_sva.sv
module secded_rd_chk_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_valid_i,
  input logic [38:0] rd_word_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_data_o,
  input logic        sbe_o,
  input logic        mbe_o,
  input logic [7:0]  syn_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_o && mbe_o)); // R8
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_o || mbe_o) |-> rd_valid_o); // R8
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rd_valid_o && !sbe_o && !mbe_o); // R10
  AST_SBE_SYN_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_o |-> !syn_o[7] && (^syn_o[6:0])); // R5
  AST_MBE_SYN_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbe_o |-> syn_o != 8'h00); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_o || mbe_o) |-> syn_o == $past(syn_o)); // R9
  AST_CLEAN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i ##1 (rd_valid_o && !sbe_o && !mbe_o) |-> rd_data_o == $past(rd_word_i[31:0])); // R4
endmodule

bind secded_rd_chk secded_rd_chk_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_valid_i (rd_valid_i),
  .rd_word_i  (rd_word_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .sbe_o      (sbe_o),
  .mbe_o      (mbe_o),
  .syn_o      (syn_o)
);

// File: tb/secded_rd_chk_tb.sv
`timescale 1ns/1ps
module secded_rd_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [6:0]  wr_ecc_o;
  logic        rd_valid_i = 1'b0;
  logic [38:0] rd_word_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        sbe_o, mbe_o;
  logic [7:0]  syn_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [6:0] col [39];  // bit position -> column; 32..38 are check bits

  always #5 clk_i = ~clk_i;

  secded_rd_chk dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_fixed(input int i);
    return (i <= 8) || (i == 21) || (i == 31);
  endfunction

  task automatic make_cols();
    logic [6:0] fixed_v [11];
    int fixed_i [11];
    int nxt;
    fixed_v = '{7'h43,7'h45,7'h46,7'h49,7'h4a,7'h4c,7'h51,7'h52,7'h54,7'h4f,7'h07};
    fixed_i = '{0,1,2,3,4,5,6,7,8,21,31};
    for (int k = 0; k < 11; k++) col[fixed_i[k]] = fixed_v[k];  // R2
    nxt = 0;
    for (int v = 0; v < 128; v++) begin  // R3
      logic clash;
      clash = 1'b0;
      for (int k = 0; k < 11; k++) if (fixed_v[k] == 7'(v)) clash = 1'b1;
      if ($countones(7'(v)) == 3 && !clash) begin
        while (nxt < 32 && is_fixed(nxt)) nxt++;
        if (nxt < 32) begin col[nxt] = 7'(v); nxt++; end
      end
    end
    for (int j = 0; j < 7; j++) col[32 + j] = 7'(1 << j);
  endtask

  function automatic logic [6:0] enc(input logic [31:0] d);
    logic [6:0] e;
    e = '0;
    for (int i = 0; i < 32; i++) if (d[i]) e ^= col[i];
    return e;
  endfunction

  task automatic rd(input logic [38:0] w);
    @(negedge clk_i);
    rd_valid_i = 1'b1;
    rd_word_i  = w;
    @(posedge clk_i);
    #1;
    rd_valid_i = 1'b0;
  endtask

  initial begin
    logic [31:0] pats [3];
    logic [38:0] cw;
    logic [7:0]  prev;
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_1E96};
    make_cols();
    repeat (3) @(posedge clk_i);
    #1;
    chk(!rd_valid_o && !sbe_o && !mbe_o, "R9 reset flags", {rd_valid_o, sbe_o, mbe_o}, 0);
    chk(syn_o == 8'h00, "R9 reset syn", syn_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: encoder sweep
    for (int i = 0; i < 32; i++) begin
      wr_data_i = 32'h1 << i;
      #1;
      chk(wr_ecc_o == enc(wr_data_i), "R1 walk", wr_ecc_o, enc(wr_data_i));
    end
    for (int p = 0; p < 3; p++) begin
      wr_data_i = pats[p];
      #1;
      chk(wr_ecc_o == enc(wr_data_i), "R1 pattern", wr_ecc_o, enc(wr_data_i));
    end

    // R4: clean reads
    for (int p = 0; p < 3; p++) begin
      cw = {enc(pats[p]), pats[p]};
      rd(cw);
      chk(rd_valid_o && !sbe_o && !mbe_o, "R4 clean flags", {rd_valid_o, sbe_o, mbe_o}, 3'b100);
      chk(rd_data_o == pats[p], "R4 clean data", rd_data_o, pats[p]);
      chk(syn_o == 8'h00, "R9 no capture on clean", syn_o, 0);
    end

    // R5/R6: every single flip
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 39; b++) begin
        cw = {enc(pats[p]), pats[p]};
        cw[b] = ~cw[b];
        rd(cw);
        chk(sbe_o && !mbe_o && rd_valid_o, b < 32 ? "R5 sbe flag" : "R6 sbe flag", {sbe_o, mbe_o}, 2'b10);
        chk(rd_data_o == pats[p], b < 32 ? "R5 corrected" : "R6 data kept", rd_data_o, pats[p]);
        chk(syn_o == {1'b0, col[b]},
            b < 32 ? (is_fixed(b) ? "R2 syndrome" : "R3 syndrome") : "R6 syndrome", syn_o, {1'b0, col[b]});
        // R9: hold across a clean read
        prev = syn_o;
        rd({enc(pats[p]), pats[p]});
        chk(syn_o == prev, "R9 hold", syn_o, prev);
      end
    end

    // R10: corrupt word without strobe
    prev = syn_o;
    cw = {enc(32'h1234_5678), 32'h1234_5678};
    cw[3] = ~cw[3]; cw[9] = ~cw[9];
    @(negedge clk_i);
    rd_word_i = cw;
    @(posedge clk_i);
    #1;
    chk(!rd_valid_o && !sbe_o && !mbe_o, "R10 quiet", {rd_valid_o, sbe_o, mbe_o}, 0);
    chk(syn_o == prev, "R10 syn kept", syn_o, prev);

    // R7/R8: every pair of flips
    for (int a = 0; a < 39; a++) begin
      for (int b = a + 1; b < 39; b++) begin
        logic [7:0] es;
        cw = {enc(pats[2]), pats[2]};
        cw[a] = ~cw[a];
        cw[b] = ~cw[b];
        es = {1'b1, col[a] ^ col[b]};
        rd(cw);
        chk(mbe_o && !sbe_o && rd_valid_o, "R7 R8 mbe flag", {sbe_o, mbe_o}, 2'b01);
        chk(syn_o == es, "R7 syndrome", syn_o, es);
      end
    end

    // R8: flag lasts one cycle
    @(posedge clk_i);
    #1;
    chk(!sbe_o && !mbe_o, "R8 one cycle", {sbe_o, mbe_o}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule